// File: doc/BRIEF.md
# Programmable Horizontal Pulse Generator

This block sets the line timing of a video path that runs on a line-locked pixel clock. A line counter divides the pixel clock by a programmable line length. Each time the count returns to zero, the block sends a horizontal reference pulse to an external phase detector, which closes the clock loop. The same counter drives three control pulses for each line: a write enable for a first memory, a write enable for a second memory, and a clamp pulse.

Each pulse has a programmable rising position and falling position. Both are given on a grid of four pixels. The two write enables also take a two-bit fine offset that moves both edges by zero to three pixels. The clamp pulse always stays on the coarse grid. A window enable from the vertical timing logic gates each pulse, so the pulses appear only on the lines that logic selects.

For use with a digital front end that supplies its own clock and line reference, an external-reference mode turns off the reference output. In this mode the counter restarts on the line strobe that the front end delivers.

Top module: `hpulse_gen`

## Requirements
- R1: While reset is low at a clock edge, the reference output and all pulse outputs are low after that edge. The first active edge after reset brings the count to 0, so the reference output goes high one edge after release.
- R2: In internal mode the count steps by one on each clock and returns to 0 on the edge after it reaches or exceeds `line_len_m1_i`. A line therefore lasts `line_len_m1_i`+1 clocks.
- R3: In internal mode `ref_o` is high exactly while the count is in 0..15. Its value is registered so that it lines up with the count.
- R4: Pulse channel i (field `[9*i +: 9]` of `start_i`/`stop_i`) is high while the count c satisfies P_s <= c < P_e, where P = 4*coarse + fine. When P_s > P_e the window wraps across the end of the line (c >= P_s or c < P_e).
- R5: Channels 0 and 1 (the two write enables) take the fine offset from `fine_i[2*i +: 2]`. This moves both edges later by 0 to 3 clocks.
- R6: Channel 2 (clamp) ignores its fine field `fine_i[5:4]`. Its edges always fall on multiples of 4.
- R7: A channel whose start position equals its stop position never goes high.
- R8: A channel's output is low on the edge after its `win_en_i` bit is sampled low. The window enable takes effect on the same edge as the count it is paired with.
- R9: With `ext_mode_i` high, `ref_o` is low. The count clears to 0 on an edge where `ext_ref_i` is high. Otherwise it increments, and it holds at 2047 (all ones) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_len_m1_i | input | 11 | Line length in pixels minus one (internal mode) |
| ext_mode_i | input | 1 | 1: count follows the external line strobe |
| ext_ref_i | input | 1 | External line strobe, used in external mode |
| start_i | input | 27 | Coarse rising position for each channel, 9 bits each |
| stop_i | input | 27 | Coarse falling position for each channel, 9 bits each |
| fine_i | input | 6 | Fine offset for each channel, 2 bits each |
| win_en_i | input | 3 | Vertical window enable for each channel |
| ref_o | output | 1 | Horizontal reference pulse to the phase detector |
| pulse_o | output | 3 | Gated pulses: bit 0 write enable A, bit 1 write enable B, bit 2 clamp |

## Verification
The assertions assume that each register input stays constant within the clock period in which it is sampled. They also assume that the reference window of 16 clocks is shorter than the line. The wrap and strobe properties then hold for any order of mode changes. The stimulus changes configuration, window enables and the strobe only just after a falling edge. It keeps every programmed edge inside the active line length, and it always programs a line longer than 16 clocks. Pulse checks are paused for two full lines after each configuration change. This lets the set/clear state left over from the previous setting run out before a window is compared.

// File: rtl/hpg_pkg.sv
// Package: shared types and default configuration values for the
// horizontal pulse generator.
// Assumes: coarse grid step equals 2**fine width, so a pixel position is
// the coarse value with the fine offset appended below it.
package hpg_pkg;

    // Edge-match results for one pulse channel on the coming count.
    typedef struct packed {
        logic rise_hit;
        logic fall_hit;
    } hpg_hits_t;

    // Default channel roles: bit i set means channel i honours fine offset.
    localparam logic [2:0] HPG_FINE_MASK_DEF = 3'b011;

    // Default width of the high phase of the reference pulse, in clocks.
    localparam int HPG_REF_LEN_DEF = 16;

endpackage

// File: rtl/hpg_line_counter.sv
// Line counter: divides the pixel clock by a programmable line length,
// or, in external mode, restarts on an external line strobe.
// Assumes: len_m1_i is stable across a line; reset value is all ones so
// the first active edge after reset produces count 0.
module hpg_line_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_m1_i,
    input  logic             ext_mode_i,
    input  logic             ext_ref_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nx_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // Next-count selection for both modes.
    always_comb begin
        if (ext_mode_i) begin
            if (ext_ref_i) begin
                cnt_nx = '0;
            end else if (cnt_q == CNT_MAX) begin
                cnt_nx = cnt_q;
            end else begin
                cnt_nx = cnt_q + CNT_ONE;
            end
        end else begin
            if (cnt_q >= len_m1_i) begin
                cnt_nx = '0;
            end else begin
                cnt_nx = cnt_q + CNT_ONE;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MAX;
        end else begin
            cnt_q <= cnt_nx;
        end
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_nx;

endmodule

// File: rtl/hpg_ref_gen.sv
// Reference pulse generator: drives the phase-detector reference high for
// the first REF_LEN counts of each line, and low in external mode where
// the reference arrives from outside instead.
// Assumes: REF_LEN is smaller than the shortest line in use.
module hpg_ref_gen #(
    parameter int CNT_W   = 11,
    parameter int REF_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nx_i,
    input  logic             ext_mode_i,
    output logic             ref_o
);

    localparam logic [CNT_W-1:0] REF_END = REF_LEN[CNT_W-1:0];

    logic ref_q;

    // Register the reference so it lines up with the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= !ext_mode_i && (cnt_nx_i < REF_END);
        end
    end

    assign ref_o = ref_q;

endmodule

// File: rtl/hpg_edge_pos.sv
// Edge position: turns a coarse grid value and a fine offset into a pixel
// position. Channels built without fine support force the offset to 0.
// Assumes: the coarse grid step is 2**FINE_W pixels.
module hpg_edge_pos #(
    parameter int POS_W    = 9,
    parameter int FINE_W   = 2,
    parameter bit USE_FINE = 1'b1
) (
    input  logic [POS_W-1:0]        coarse_i,
    input  logic [FINE_W-1:0]       fine_i,
    output logic [POS_W+FINE_W-1:0] pos_o
);

    localparam logic [FINE_W-1:0] FINE_KEEP = USE_FINE ? '1 : '0;

    // Append the (possibly masked) fine offset below the coarse value.
    assign pos_o = {coarse_i, fine_i & FINE_KEEP};

endmodule

// File: rtl/hpg_pulse_chan.sv
// Pulse channel: a set/clear state bit switched by two edge comparators
// on the coming count, then gated by the vertical window enable into a
// registered output.
// Assumes: both edges lie inside the active line; when the edges match
// together the clear wins, so equal positions never raise the pulse.
module hpg_pulse_chan #(
    parameter int POS_W    = 9,
    parameter int FINE_W   = 2,
    parameter bit USE_FINE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [POS_W+FINE_W-1:0] cnt_nx_i,
    input  logic [POS_W-1:0]        start_i,
    input  logic [POS_W-1:0]        stop_i,
    input  logic [FINE_W-1:0]       fine_i,
    input  logic                    en_i,
    output logic                    pulse_o
);

    import hpg_pkg::*;

    localparam int CNT_W = POS_W + FINE_W;

    logic [CNT_W-1:0] rise_pos;
    logic [CNT_W-1:0] fall_pos;
    hpg_hits_t        hits;
    logic             st_q;
    logic             st_nx;
    logic             pulse_q;

    hpg_edge_pos #(
        .POS_W   (POS_W),
        .FINE_W  (FINE_W),
        .USE_FINE(USE_FINE)
    ) i_rise_pos (
        .coarse_i(start_i),
        .fine_i  (fine_i),
        .pos_o   (rise_pos)
    );

    hpg_edge_pos #(
        .POS_W   (POS_W),
        .FINE_W  (FINE_W),
        .USE_FINE(USE_FINE)
    ) i_fall_pos (
        .coarse_i(stop_i),
        .fine_i  (fine_i),
        .pos_o   (fall_pos)
    );

    // Compare both edge positions against the coming count.
    always_comb begin
        hits.rise_hit = (cnt_nx_i == rise_pos);
        hits.fall_hit = (cnt_nx_i == fall_pos);
    end

    // Next window state: clear has priority over set.
    always_comb begin
        if (hits.fall_hit) begin
            st_nx = 1'b0;
        end else if (hits.rise_hit) begin
            st_nx = 1'b1;
        end else begin
            st_nx = st_q;
        end
    end

    // Window state and gated output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_nx;
            pulse_q <= st_nx && en_i;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/hpulse_gen.sv
// Horizontal pulse generator top: one line counter, one reference pulse
// generator and NUM_CH gated pulse channels placed on a coarse grid with
// an optional fine offset per channel.
// Assumes: channel i uses fields [i*POS_W +: POS_W] of start_i/stop_i and
// [i*FINE_W +: FINE_W] of fine_i; FINE_MASK[i] selects fine support.
module hpulse_gen #(
    parameter int                POS_W     = 9,
    parameter int                FINE_W    = 2,
    parameter int                NUM_CH    = 3,
    parameter int                REF_LEN   = hpg_pkg::HPG_REF_LEN_DEF,
    parameter logic [NUM_CH-1:0] FINE_MASK = hpg_pkg::HPG_FINE_MASK_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [POS_W+FINE_W-1:0]    line_len_m1_i,
    input  logic                       ext_mode_i,
    input  logic                       ext_ref_i,
    input  logic [NUM_CH*POS_W-1:0]    start_i,
    input  logic [NUM_CH*POS_W-1:0]    stop_i,
    input  logic [NUM_CH*FINE_W-1:0]   fine_i,
    input  logic [NUM_CH-1:0]          win_en_i,
    output logic                       ref_o,
    output logic [NUM_CH-1:0]          pulse_o
);

    localparam int CNT_W = POS_W + FINE_W;

    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] line_cnt_nx;

    hpg_line_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_m1_i  (line_len_m1_i),
        .ext_mode_i(ext_mode_i),
        .ext_ref_i (ext_ref_i),
        .cnt_o     (line_cnt),
        .cnt_nx_o  (line_cnt_nx)
    );

    hpg_ref_gen #(
        .CNT_W  (CNT_W),
        .REF_LEN(REF_LEN)
    ) i_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_nx_i  (line_cnt_nx),
        .ext_mode_i(ext_mode_i),
        .ref_o     (ref_o)
    );

    // One pulse channel per output bit; the mask picks the fine variant.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        hpg_pulse_chan #(
            .POS_W   (POS_W),
            .FINE_W  (FINE_W),
            .USE_FINE(FINE_MASK[ch])
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_nx_i(line_cnt_nx),
            .start_i (start_i[ch*POS_W +: POS_W]),
            .stop_i  (stop_i[ch*POS_W +: POS_W]),
            .fine_i  (fine_i[ch*FINE_W +: FINE_W]),
            .en_i    (win_en_i[ch]),
            .pulse_o (pulse_o[ch])
        );
    end

endmodule

// File: rtl/hpg_checker.sv
// Checker: timing properties of the horizontal pulse generator, bound to
// the top module. Observes ports and the line counter register.
// Assumes: inputs are stable around each rising clock edge.
module hpg_checker #(
    parameter int CNT_W   = 11,
    parameter int NUM_CH  = 3,
    parameter int REF_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] line_len_m1_i,
    input logic             ext_mode_i,
    input logic             ext_ref_i,
    input logic [NUM_CH-1:0] win_en_i,
    input logic             ref_o,
    input logic [NUM_CH-1:0] pulse_o,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] REF_END = REF_LEN[CNT_W-1:0];

    logic       was_reset_q;
    logic [7:0] ref_run_q;

    // Remember that reset was applied at the last edge.
    always_ff @(posedge clk) begin
        was_reset_q <= !rst_n;
    end

    // Count consecutive high samples of the reference output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_run_q <= '0;
        end else if (!ref_o) begin
            ref_run_q <= '0;
        end else if (ref_run_q != 8'hFF) begin
            ref_run_q <= ref_run_q + 8'd1;
        end
    end

    // Outputs are quiet after a reset edge.
    always @(negedge clk) begin
        if (was_reset_q) begin
            assert_reset_quiet_R1: assert (!ref_o && (pulse_o == '0))
                else $error("outputs active after reset edge");
        end
    end

    // Reference high phase never exceeds its programmed length.
    always @(posedge clk) begin
        if (rst_n) begin
            assert_ref_width_R3: assert (ref_run_q <= 8'(REF_LEN))
                else $error("reference pulse too long");
        end
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && (cnt >= line_len_m1_i)) |=> (cnt == '0));

    assert_ref_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |=> (ref_o == (cnt < REF_END)));

    assert_ext_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode_i && ext_ref_i) |=> (cnt == '0));

    assert_ext_ref_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_i |=> !ref_o);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !win_en_i[ch] |=> !pulse_o[ch]);
    end

endmodule

bind hpulse_gen hpg_checker #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH),
    .REF_LEN(REF_LEN)
) i_hpg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_len_m1_i(line_len_m1_i),
    .ext_mode_i   (ext_mode_i),
    .ext_ref_i    (ext_ref_i),
    .win_en_i     (win_en_i),
    .ref_o        (ref_o),
    .pulse_o      (pulse_o),
    .cnt          (line_cnt)
);

// File: tb/test_hpulse_gen.sv
// Bench: sweeps edge positions, fine offsets and line lengths, then runs
// external-strobe mode; expected outputs come from an arithmetic model.
module test_hpulse_gen;

    localparam int POS_W = 9;
    localparam int FW    = 2;
    localparam int NCH   = 3;
    localparam int CW    = POS_W + FW;
    localparam int MAXC  = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     line_len_m1_i = CW'(79);
    logic              ext_mode_i = 1'b0;
    logic              ext_ref_i = 1'b0;
    logic [NCH*POS_W-1:0] start_i = '0;
    logic [NCH*POS_W-1:0] stop_i = '0;
    logic [NCH*FW-1:0] fine_i = '0;
    logic [NCH-1:0]    win_en_i = '1;
    logic              ref_o;
    logic [NCH-1:0]    pulse_o;

    int   n_chk = 0;
    int   n_bad = 0;
    int   ecnt = MAXC;
    logic [NCH-1:0] en_prev = '0;
    bit   chk_on = 1'b0;
    int   cfg_s [NCH];
    int   cfg_e [NCH];
    int   cfg_f [NCH];

    always #5 clk = ~clk;

    hpulse_gen i_hpulse_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_len_m1_i(line_len_m1_i),
        .ext_mode_i   (ext_mode_i),
        .ext_ref_i    (ext_ref_i),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .fine_i       (fine_i),
        .win_en_i     (win_en_i),
        .ref_o        (ref_o),
        .pulse_o      (pulse_o)
    );

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input bit got, input bit exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s count=%0d actual=%0b expected=%0b", tag, what, ecnt, got, exp);
        end
    endtask

    function automatic bit in_win(input int c, input int s, input int e);
        if (s == e) return 1'b0;
        if (s < e) return (c >= s) && (c < e);
        return (c >= s) || (c < e);
    endfunction

    task automatic drive_cfg();
        for (int i = 0; i < NCH; i++) begin
            start_i[i*POS_W +: POS_W] = POS_W'(cfg_s[i]);
            stop_i[i*POS_W +: POS_W]  = POS_W'(cfg_e[i]);
            fine_i[i*FW +: FW]        = FW'(cfg_f[i]);
        end
    endtask

    // Count model from R2 and R9; window enable sampled per R8.
    always @(posedge clk) begin
        if (!rst_n) begin
            ecnt    <= MAXC;
            en_prev <= '0;
        end else begin
            if (ext_mode_i) begin
                if (ext_ref_i) ecnt <= 0;
                else if (ecnt != MAXC) ecnt <= ecnt + 1;
            end else begin
                if (ecnt >= int'(line_len_m1_i)) ecnt <= 0;
                else ecnt <= ecnt + 1;
            end
            en_prev <= win_en_i;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            bit    exp_ref;
            string rtag;
            exp_ref = ext_mode_i ? 1'b0 : (ecnt < 16);
            rtag = ext_mode_i ? "R9" : ((ecnt == 0) ? "R2" : "R3");
            check(ref_o, exp_ref, rtag, "ref");
            for (int i = 0; i < NCH; i++) begin
                int    fo;
                int    ps;
                int    pe;
                bit    ex;
                string ptag;
                fo = (i < 2) ? cfg_f[i] : 0;
                ps = 4 * cfg_s[i] + fo;
                pe = 4 * cfg_e[i] + fo;
                ex = in_win(ecnt, ps, pe) && en_prev[i];
                if (!en_prev[i]) ptag = "R8";
                else if (cfg_s[i] == cfg_e[i]) ptag = "R7";
                else if (i == 2 && cfg_f[i] != 0) ptag = "R6";
                else if (i < 2 && cfg_f[i] != 0) ptag = "R5";
                else ptag = "R4";
                check(pulse_o[i], ex, ptag, $sformatf("pulse%0d", i));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            cfg_s[i] = 0;
            cfg_e[i] = 0;
            cfg_f[i] = 0;
        end
        drive_cfg();
        // R1: outputs quiet while reset is held.
        repeat (3) begin
            @(negedge clk);
            check(ref_o, 1'b0, "R1", "ref in reset");
            check(pulse_o != '0, 1'b0, "R1", "pulses in reset");
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(ref_o, 1'b1, "R1", "ref after release");
        #1 chk_on = 1'b1;

        // Internal-mode sweep over two line lengths.
        for (int li = 0; li < 2; li++) begin
            int len;
            int ncoarse;
            len = (li == 0) ? 80 : 52;
            ncoarse = len / 4;
            for (int s = 0; s < ncoarse; s += 3) begin
                for (int e = 0; e < ncoarse; e += 4) begin
                    for (int f = 0; f < 4; f++) begin
                        @(negedge clk);
                        #1;
                        chk_on = 1'b0;
                        cfg_s[0] = s; cfg_e[0] = e; cfg_f[0] = f;
                        cfg_s[1] = e; cfg_e[1] = s; cfg_f[1] = 3 - f;
                        cfg_s[2] = s; cfg_e[2] = (e + 2) % ncoarse; cfg_f[2] = f;
                        drive_cfg();
                        line_len_m1_i = CW'(len - 1);
                        win_en_i = '1;
                        repeat (2 * len) @(negedge clk);
                        #1 chk_on = 1'b1;
                        repeat (len) @(negedge clk);
                        #1 win_en_i = NCH'((s + e + f) % 8);
                        repeat (len) @(negedge clk);
                    end
                end
            end
        end

        // R9: external strobe mode, then hold at the count limit.
        @(negedge clk);
        #1;
        chk_on = 1'b0;
        cfg_s[0] = 2; cfg_e[0] = 6; cfg_f[0] = 1;
        cfg_s[1] = 7; cfg_e[1] = 1; cfg_f[1] = 2;
        cfg_s[2] = 3; cfg_e[2] = 3; cfg_f[2] = 1;
        drive_cfg();
        win_en_i = '1;
        ext_mode_i = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1 ext_ref_i = 1'b1;
            @(negedge clk);
            #1 ext_ref_i = 1'b0;
            if (k == 2) chk_on = 1'b1;
            repeat (38) @(negedge clk);
        end
        repeat (2100) @(negedge clk);
        #1 chk_on = 1'b0;
        ext_mode_i = 1'b0;
        repeat (3 * 80) @(negedge clk);
        #1 chk_on = 1'b1;
        repeat (80) @(negedge clk);
        #1 chk_on = 1'b0;
        finish_run();
    end

endmodule